// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block puts a NOR-flash style command front end in front of a small byte-wide storage array. It accepts two command dialects through one write strobe. The first dialect uses single-byte opcodes that switch the read mode, arm a program or a block erase, or set and clear a master lock flag. The second dialect uses multi-cycle unlock sequences written to fixed command addresses, which lead to identification read, single-byte program, chip erase or sector erase.

Erase operations clear their range of the array to 0xFF at once. A countdown then models the erase time. While the countdown runs, the block reports a status byte and drives a busy output. Array size, block size, sector size and the length of one modelled second (in clock cycles) are parameters, so the timing can be scaled down for simulation.

The read port returns one of three things, depending on the current mode: array contents, the status byte, or identification bytes. Read data is registered.

Top module: `flash_cmd_top`

## Requirements
- R1: After a synchronous active-low reset, the block is in array-read mode, every array byte reads 0xFF, the status byte is 0x80, `busy` is 0 and `master_lock` is 0.
- R2: In array-read, status-read, ID-read and unlock-ID mode, the following single-byte commands apply at any address:
  - 0xF0 or 0xFF selects array read.
  - 0x90 selects ID read.
  - 0x70 selects status read.
  - 0x50 loads status 0x80 and selects status read.
  - An unrecognised byte leaves the mode unchanged.
- R3: Writing 0x40 or 0x10 arms a program. The next write stores its data byte at its address, loads status 0x80 and selects status read.
- R4: Writing 0x20 arms a block erase.
  - While armed, any byte other than 0xD0 is ignored and the machine stays armed.
  - 0xD0 sets the whole block (2^BLK_W bytes) that contains the write address to 0xFF, loads status 0x00, selects status read and starts the busy countdown.
- R5: Writing 0x60 enters lock setup. The next write then:
  - sets `master_lock` if its data is 0xF1;
  - clears `master_lock` if its data is 0xD0;
  - leaves `master_lock` unchanged for any other data;
  - in every case returns the machine to array read.
- R6: An unlock sequence is started by 0xAA at an address whose low 12 bits are 0x555 (0xAA anywhere else is ignored). The sequence continues with 0x55 at address 0x2AA or 0x2AAA. Any other second write returns the machine to array read.
- R7: After the two unlock cycles, the third write is decoded only at address 0x555 or 0x5555:
  - 0x90 selects unlock-ID read, which reads like ID read.
  - 0x80 enters erase setup.
  - 0xA0 arms a single-byte program.
  - Every other data or address returns the machine to array read.
- R8: In single-byte-program mode, the next write stores its data at its address, and the machine returns to array read.
- R9: Erase setup waits for a second unlock pair: 0xAA at low 12 bits 0x555, then 0x55 at 0x2AA or 0x2AAA. Writes that do not match the expected step are ignored, and the machine keeps waiting.
- R10: After the second unlock pair, either of two writes starts an erase:
  - 0x10 at low 12 bits 0x555 erases the whole array.
  - 0x30 at any address erases the sector containing that address.

  Either erase loads status 0x08 and enters erase-busy mode. In that mode, reads return the status byte and writes are ignored.
- R11: The busy countdown lasts a fixed number of cycles, where T_SEC is the length of one modelled second:
  - Block erase: T_SEC cycles.
  - Sector erase: T_SEC/8 cycles with small sectors (SMALL_SECT=1), or T_SEC cycles with large sectors.
  - Chip erase: T_SEC cycles with small sectors, or 16*T_SEC cycles with large sectors.

  `busy` rises on the clock edge that accepts the erase and falls exactly that many edges later.
- R12: On the edge where the countdown ends, the status byte becomes 0x80. If the machine was in erase-busy mode, it returns to array read.
- R13: `rd_data` is registered and reflects `rd_addr` and the mode of the preceding clock edge. In ID and unlock-ID mode, offset 0 returns MFR_ID, offset 1 returns DEV_ID, and every other offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one command or data byte per cycle |
| wr_addr | input | BUS_AW | Write address; command addresses are decoded on its low 12 or 16 bits |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | BUS_AW | Read address |
| rd_data | output | 8 | Registered read data: array byte, status or ID byte |
| busy | output | 1 | High while an erase countdown runs |
| master_lock | output | 1 | Master lock flag |

## Verification
A write presented with `wr_en` takes effect on the next rising edge. A read address applied in the same cycle as a write still sees the old mode, and its data appears after the next edge. The scoreboard therefore stamps each expected read with the monitor's edge count plus one, and compares it 2 ns after that edge. Reads are issued at falling edges, so a read issued after a write's edge always sees the new mode. Erase durations are measured as the number of rising edges between the edge that accepted the erase and the first falling edge at which `busy` reads low. That number must equal the R11 value exactly.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
// Shared types and command codes for the flash command interpreter.
// Assumes byte-wide data; command bytes are compared on all 8 bits.
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        M_ARRAY,      // array read
        M_STATUS,     // status read
        M_ID,         // identification read
        M_UID,        // identification read reached through unlock
        M_PGM_ARM,    // single-opcode program armed
        M_BLK_ARM,    // block erase armed, waiting for confirm
        M_LOCK,       // lock setup
        M_UNLK1,      // first unlock cycle seen
        M_UNLK2,      // second unlock cycle seen
        M_ERS1,       // erase setup, waiting for 0xAA
        M_ERS2,       // erase setup, waiting for 0x55
        M_ERS3,       // erase setup, waiting for erase opcode
        M_BYTE,       // unlock byte program armed
        M_BUSY        // erase in progress
    } mode_t;

    typedef enum logic [1:0] {
        RS_ARRAY,
        RS_STATUS,
        RS_ID
    } rsel_t;

    localparam logic [7:0] OP_RST_A    = 8'hF0;
    localparam logic [7:0] OP_RST_B    = 8'hFF;
    localparam logic [7:0] OP_IDREAD   = 8'h90;
    localparam logic [7:0] OP_PGM_A    = 8'h40;
    localparam logic [7:0] OP_PGM_B    = 8'h10;
    localparam logic [7:0] OP_CLRSTAT  = 8'h50;
    localparam logic [7:0] OP_BLKERASE = 8'h20;
    localparam logic [7:0] OP_LOCKSET  = 8'h60;
    localparam logic [7:0] OP_STATREAD = 8'h70;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCKON   = 8'hF1;
    localparam logic [7:0] OP_KEY1     = 8'hAA;
    localparam logic [7:0] OP_KEY2     = 8'h55;
    localparam logic [7:0] OP_ERSETUP  = 8'h80;
    localparam logic [7:0] OP_BYTEPGM  = 8'hA0;
    localparam logic [7:0] OP_CHIPERS  = 8'h10;
    localparam logic [7:0] OP_SECTERS  = 8'h30;

    localparam logic [7:0] ST_READY    = 8'h80;
    localparam logic [7:0] ST_ERASING  = 8'h08;
    localparam logic [7:0] ST_BLKBUSY  = 8'h00;

endpackage

// File: rtl/flash_busy_timer.sv
`timescale 1ns/1ps
// Erase busy countdown. A load starts a run of 'load_val' cycles;
// 'done' pulses in the last cycle of the run, 'busy' is high throughout.
// Assumes load_val is non-zero whenever load is asserted.
module flash_busy_timer #(
    parameter int TW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          busy,
    output logic          done
);

    logic [TW-1:0] count;

    // Reload on request, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    // Status outputs derived from the remaining count.
    always_comb begin
        busy = (count != '0);
        done = (count == TW'(1));
    end

    a_r11_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && !load) |=> (count == $past(count) - 1'b1))
        else $error("timer did not decrement");

    a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)))
        else $error("timer load lost");

endmodule

// File: rtl/flash_array.sv
`timescale 1ns/1ps
// Byte storage with one program port and a range erase.
// An erase clears every byte whose address agrees with erase_addr above
// bit erase_lsb (erase_lsb == ARR_AW clears all). Program and erase are
// never requested together. Reset fills the array with 0xFF.
module flash_array #(
    parameter int ARR_AW = 10,
    parameter int LW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ARR_AW-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              erase_en,
    input  logic [ARR_AW-1:0] erase_addr,
    input  logic [LW-1:0]     erase_lsb,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [7:0]        rd_byte
);

    localparam int DEPTH = 1 << ARR_AW;

    logic [7:0] mem [DEPTH];

    // Reset fill, range erase, or single-byte program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++)
                if ((ARR_AW'(i) >> erase_lsb) == (erase_addr >> erase_lsb))
                    mem[i] <= 8'hFF;
        end else if (prog_en) begin
            mem[prog_addr] <= prog_data;
        end
    end

    // Asynchronous read; the top registers the result.
    always_comb rd_byte = mem[rd_addr];

    a_r3_program_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !erase_en) |=> (mem[$past(prog_addr)] == $past(prog_data)))
        else $error("programmed byte not stored");

    a_r4_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem[$past(erase_addr)] == 8'hFF))
        else $error("erase left data");

endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
// Command decoder for both dialects: single-byte opcodes and unlock
// sequences at fixed addresses. Holds mode, status byte and lock flag,
// and issues program/erase requests and timer loads.
// Assumes BUS_AW >= 16 so that 16-bit command addresses can be decoded.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int BUS_AW       = 16,
    parameter int ARR_AW       = 10,
    parameter int BLK_W        = 8,
    parameter int SECT_SMALL_W = 6,
    parameter bit SMALL_SECT   = 1'b1,
    parameter int T_SEC        = 64,
    parameter int LW           = 4,
    parameter int TW           = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              tmr_busy,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    output logic              prog_en,
    output logic              erase_en,
    output logic [LW-1:0]     erase_lsb,
    output rsel_t             rd_sel,
    output logic [7:0]        status,
    output logic              lock
);

    localparam int SECT_W = SMALL_SECT ? SECT_SMALL_W : BLK_W;
    localparam int T_SECT = SMALL_SECT ? (T_SEC / 8) : T_SEC;
    localparam int T_CHIP = SMALL_SECT ? T_SEC : (16 * T_SEC);
    localparam int T_BLK  = T_SEC;

    mode_t      mode, nxt_mode;
    logic [7:0] nxt_status;
    logic       nxt_lock;
    logic       a12_555, a16_2aa, a16_555;

    // Command address matches on the low 12 or 16 address bits.
    always_comb begin
        a12_555 = (wr_addr[11:0] == 12'h555);
        a16_2aa = (wr_addr[15:0] == 16'h02AA) || (wr_addr[15:0] == 16'h2AAA);
        a16_555 = (wr_addr[15:0] == 16'h0555) || (wr_addr[15:0] == 16'h5555);
    end

    // Next-state decode for one write plus timer completion.
    always_comb begin
        nxt_mode   = mode;
        nxt_status = status;
        nxt_lock   = lock;
        prog_en    = 1'b0;
        erase_en   = 1'b0;
        erase_lsb  = '0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        if (wr_en) begin
            case (mode)
                M_ARRAY, M_STATUS, M_ID, M_UID: begin
                    case (wr_data)
                        OP_RST_A, OP_RST_B: nxt_mode = M_ARRAY;
                        OP_IDREAD:          nxt_mode = M_ID;
                        OP_PGM_A, OP_PGM_B: nxt_mode = M_PGM_ARM;
                        OP_CLRSTAT: begin
                            nxt_status = ST_READY;
                            nxt_mode   = M_STATUS;
                        end
                        OP_BLKERASE:        nxt_mode = M_BLK_ARM;
                        OP_LOCKSET:         nxt_mode = M_LOCK;
                        OP_STATREAD:        nxt_mode = M_STATUS;
                        OP_KEY1:            if (a12_555) nxt_mode = M_UNLK1;
                        default:            nxt_mode = mode;
                    endcase
                end
                M_PGM_ARM: begin
                    prog_en    = 1'b1;
                    nxt_status = ST_READY;
                    nxt_mode   = M_STATUS;
                end
                M_BLK_ARM: begin
                    if (wr_data == OP_CONFIRM) begin
                        erase_en   = 1'b1;
                        erase_lsb  = LW'(BLK_W);
                        nxt_status = ST_BLKBUSY;
                        nxt_mode   = M_STATUS;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(T_BLK);
                    end
                end
                M_LOCK: begin
                    if (wr_data == OP_LOCKON)
                        nxt_lock = 1'b1;
                    else if (wr_data == OP_CONFIRM)
                        nxt_lock = 1'b0;
                    nxt_mode = M_ARRAY;
                end
                M_UNLK1: begin
                    if (a16_2aa && wr_data == OP_KEY2)
                        nxt_mode = M_UNLK2;
                    else
                        nxt_mode = M_ARRAY;
                end
                M_UNLK2: begin
                    nxt_mode = M_ARRAY;
                    if (a16_555) begin
                        case (wr_data)
                            OP_IDREAD:  nxt_mode = M_UID;
                            OP_ERSETUP: nxt_mode = M_ERS1;
                            OP_BYTEPGM: nxt_mode = M_BYTE;
                            default:    nxt_mode = M_ARRAY;
                        endcase
                    end
                end
                M_ERS1: begin
                    if (a12_555 && wr_data == OP_KEY1)
                        nxt_mode = M_ERS2;
                end
                M_ERS2: begin
                    if (a16_2aa && wr_data == OP_KEY2)
                        nxt_mode = M_ERS3;
                end
                M_ERS3: begin
                    if (a12_555 && wr_data == OP_CHIPERS) begin
                        erase_en   = 1'b1;
                        erase_lsb  = LW'(ARR_AW);
                        nxt_status = ST_ERASING;
                        nxt_mode   = M_BUSY;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(T_CHIP);
                    end else if (wr_data == OP_SECTERS) begin
                        erase_en   = 1'b1;
                        erase_lsb  = LW'(SECT_W);
                        nxt_status = ST_ERASING;
                        nxt_mode   = M_BUSY;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(T_SECT);
                    end
                end
                M_BYTE: begin
                    prog_en  = 1'b1;
                    nxt_mode = M_ARRAY;
                end
                M_BUSY:  nxt_mode = M_BUSY;
                default: nxt_mode = M_ARRAY;
            endcase
        end
        if (tmr_done && !tmr_load) begin
            nxt_status = ST_READY;
            if (mode == M_BUSY)
                nxt_mode = M_ARRAY;
        end
    end

    // State registers for mode, status byte and lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= M_ARRAY;
            status <= ST_READY;
            lock   <= 1'b0;
        end else begin
            mode   <= nxt_mode;
            status <= nxt_status;
            lock   <= nxt_lock;
        end
    end

    // Read source for the current mode.
    always_comb begin
        case (mode)
            M_STATUS, M_BUSY: rd_sel = RS_STATUS;
            M_ID, M_UID:      rd_sel = RS_ID;
            default:          rd_sel = RS_ARRAY;
        endcase
    end

    a_r10_busy_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_BUSY) |-> tmr_busy)
        else $error("erase-busy mode without running timer");

    a_r12_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_BUSY && tmr_done) |=> (mode == M_ARRAY && status == ST_READY))
        else $error("erase completion not handled");

    a_r3_program_status: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PGM_ARM && wr_en) |=> (mode == M_STATUS && status == ST_READY))
        else $error("program did not enter status read");

    a_r8_byte_return: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_BYTE && wr_en) |=> (mode == M_ARRAY))
        else $error("byte program did not return to array read");

    a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_UNLK1 && wr_en && !(a16_2aa && wr_data == OP_KEY2)) |=> (mode == M_ARRAY))
        else $error("bad second unlock cycle not aborted");

    a_r4_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status) <= 1)
        else $error("illegal status value");

endmodule

// File: rtl/flash_cmd_top.sv
`timescale 1ns/1ps
// Top of the flash command interpreter: decoder, busy timer, storage
// array and the registered read multiplexer.
// Assumes BUS_AW >= 16, ARR_AW <= BUS_AW, SECT_SMALL_W <= BLK_W <= ARR_AW.
module flash_cmd_top
    import flash_cmd_pkg::*;
#(
    parameter int         BUS_AW       = 16,
    parameter int         ARR_AW       = 10,
    parameter int         BLK_W        = 8,
    parameter int         SECT_SMALL_W = 6,
    parameter bit         SMALL_SECT   = 1'b1,
    parameter int         T_SEC        = 64,
    parameter logic [7:0] MFR_ID       = 8'hC2,
    parameter logic [7:0] DEV_ID       = 8'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [BUS_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              master_lock
);

    localparam int LW = $clog2(ARR_AW + 1);
    localparam int TW = $clog2(16 * T_SEC + 1);

    logic          tmr_load, tmr_busy, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          prog_en, erase_en;
    logic [LW-1:0] erase_lsb;
    rsel_t         rd_sel;
    logic [7:0]    status;
    logic [7:0]    arr_byte;

    flash_cmd_fsm #(
        .BUS_AW(BUS_AW), .ARR_AW(ARR_AW), .BLK_W(BLK_W),
        .SECT_SMALL_W(SECT_SMALL_W), .SMALL_SECT(SMALL_SECT),
        .T_SEC(T_SEC), .LW(LW), .TW(TW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tmr_busy(tmr_busy), .tmr_done(tmr_done),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .prog_en(prog_en), .erase_en(erase_en), .erase_lsb(erase_lsb),
        .rd_sel(rd_sel), .status(status), .lock(master_lock)
    );

    flash_busy_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val),
        .busy(tmr_busy), .done(tmr_done)
    );

    flash_array #(.ARR_AW(ARR_AW), .LW(LW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .prog_en(prog_en), .prog_addr(wr_addr[ARR_AW-1:0]), .prog_data(wr_data),
        .erase_en(erase_en), .erase_addr(wr_addr[ARR_AW-1:0]), .erase_lsb(erase_lsb),
        .rd_addr(rd_addr[ARR_AW-1:0]), .rd_byte(arr_byte)
    );

    // Busy output follows the countdown.
    always_comb busy = tmr_busy;

    // Registered read data selected by the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 8'h00;
        else begin
            case (rd_sel)
                RS_STATUS: rd_data <= status;
                RS_ID: begin
                    if (rd_addr == BUS_AW'(0))
                        rd_data <= MFR_ID;
                    else if (rd_addr == BUS_AW'(1))
                        rd_data <= DEV_ID;
                    else
                        rd_data <= 8'h00;
                end
                default:   rd_data <= arr_byte;
            endcase
        end
    end

    a_r12_busy_vs_status: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (status == 8'h80))
        else $error("busy dropped without ready status");

endmodule

// File: tb/test_flash_cmd_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected bytes with their due edge,
// a monitor pops and compares them 2 ns after that edge.
module test_flash_cmd_top;

    localparam int         T_SEC  = 64;
    localparam logic [7:0] MFR    = 8'hC2;
    localparam logic [7:0] DEV    = 8'h1D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy;
    logic        master_lock;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 0;

    typedef struct {
        int         due;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    flash_cmd_top #(.T_SEC(T_SEC), .MFR_ID(MFR), .DEV_ID(DEV)) i_flash_cmd_top (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .master_lock(master_lock)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: counts edges and compares due read results.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                it = sb_q.pop_front();
                check(it.req, {24'h0, rd_data}, {24'h0, it.exp});
            end
        end
    end

    // Driver: one write on the next edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: one read whose result is due after the next edge.
    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string req);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        it.due = cyc + 1; it.exp = e; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic unlock();
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
    endtask

    // Edges from t0 until busy is seen low at a falling edge.
    task automatic wait_idle(input int t0, input int exp, input string req);
        while (busy) @(negedge clk);
        check(req, cyc - t0, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 lock", master_lock, 0);
        rd(16'h0000, 8'hFF, "R1 array erased");
        rd(16'h03FF, 8'hFF, "R1 array erased top");
        wr(16'h0000, 8'h70);
        rd(16'h0000, 8'h80, "R1 status ready");

        // R8 unlock byte program, R13 back-to-back reads
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h0010, 8'h3C);
        rd(16'h0010, 8'h3C, "R8 byte stored");
        rd(16'h0011, 8'hFF, "R13 neighbour read");

        // R3 single-opcode program, both opcodes
        wr(16'h0000, 8'h40);
        wr(16'h0020, 8'h5A);
        rd(16'h0020, 8'h80, "R3 status after program");
        wr(16'h0000, 8'hFF);
        rd(16'h0020, 8'h5A, "R3 program 0x40 stored");
        wr(16'h0000, 8'h10);
        wr(16'h0021, 8'h11);
        wr(16'h0000, 8'hF0);
        rd(16'h0021, 8'h11, "R3 program 0x10 stored");

        // R2 / R13 ID read, unknown opcode ignored, clear status
        wr(16'h0000, 8'h90);
        rd(16'h0000, MFR, "R13 ID offset 0");
        rd(16'h0001, DEV, "R13 ID offset 1");
        rd(16'h0010, 8'h00, "R13 ID other offset");
        wr(16'h0000, 8'h33);
        rd(16'h0001, DEV, "R2 unknown byte ignored");
        wr(16'h0000, 8'h50);
        rd(16'h0000, 8'h80, "R2 clear status");
        wr(16'h0000, 8'hFF);
        rd(16'h0010, 8'h3C, "R2 reset to array");

        // R6 abort on wrong second cycle; 0xAA off-address ignored
        wr(16'h0555, 8'hAA);
        wr(16'h0123, 8'h55);
        wr(16'h0000, 8'h40);  // program armed only if abort went to array mode
        wr(16'h0030, 8'h77);
        wr(16'h0000, 8'hFF);
        rd(16'h0030, 8'h77, "R6 abort to array");
        wr(16'h0556, 8'hAA);
        wr(16'h02AA, 8'h55);
        wr(16'h0555, 8'h90);
        rd(16'h0010, 8'h00, "R6 misplaced key ignored");
        wr(16'h0000, 8'hF0);

        // R7 alternate addresses to unlock-ID, then R2 exit
        wr(16'h1555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'h90);
        rd(16'h0000, MFR, "R7 unlock ID");
        wr(16'h0000, 8'hF0);
        rd(16'h0010, 8'h3C, "R2 exit unlock ID");
        unlock();
        wr(16'h0556, 8'h90);
        rd(16'h0010, 8'h3C, "R7 wrong third address");
        unlock();
        wr(16'h0555, 8'h77);
        rd(16'h0010, 8'h3C, "R7 unknown third byte");

        // R5 master lock
        wr(16'h0000, 8'h60);
        wr(16'h0000, 8'hF1);
        @(negedge clk);
        check("R5 lock set", master_lock, 1);
        rd(16'h0010, 8'h3C, "R5 back to array");
        wr(16'h0000, 8'h60);
        wr(16'h0000, 8'h12);
        @(negedge clk);
        check("R5 lock kept", master_lock, 1);
        wr(16'h0000, 8'h60);
        wr(16'h0000, 8'hD0);
        @(negedge clk);
        check("R5 lock cleared", master_lock, 0);

        // R4 block erase with ignored byte while armed
        unlock(); wr(16'h0555, 8'hA0); wr(16'h0100, 8'hA5);
        unlock(); wr(16'h0555, 8'hA0); wr(16'h00FF, 8'h66);
        wr(16'h0105, 8'h20);
        wr(16'h0000, 8'h44);
        wr(16'h0105, 8'hD0);
        t0 = cyc;
        check("R11 busy after block erase", busy, 1);
        rd(16'h0000, 8'h00, "R4 status busy");
        wait_idle(t0, T_SEC, "R11 block erase time");
        rd(16'h0000, 8'h80, "R12 status ready");
        wr(16'h0000, 8'hFF);
        rd(16'h0100, 8'hFF, "R4 block cleared");
        rd(16'h00FF, 8'h66, "R4 other block kept");

        // R9 / R10 sector erase with ignored writes
        unlock(); wr(16'h0555, 8'hA0); wr(16'h00C0, 8'h77);
        unlock();
        wr(16'h0555, 8'h80);
        wr(16'h0123, 8'h99);
        wr(16'h0555, 8'hAA);
        wr(16'h0300, 8'h11);
        wr(16'h2AAA, 8'h55);
        wr(16'h00C4, 8'h30);
        t0 = cyc;
        rd(16'h0000, 8'h08, "R10 erasing status");
        wr(16'h0000, 8'h90);
        rd(16'h0000, 8'h08, "R10 write ignored while busy");
        wait_idle(t0, T_SEC / 8, "R11 sector erase time");
        rd(16'h00C0, 8'hFF, "R10 sector cleared");
        rd(16'h00FF, 8'hFF, "R10 sector end cleared");
        rd(16'h0010, 8'h3C, "R12 array mode after erase");
        wr(16'h0000, 8'h70);
        rd(16'h0000, 8'h80, "R12 status after erase");
        wr(16'h0000, 8'hFF);

        // R10 chip erase
        unlock();
        wr(16'h5555, 8'h80);
        unlock();
        wr(16'h0555, 8'h10);
        t0 = cyc;
        wait_idle(t0, T_SEC, "R11 chip erase time");
        rd(16'h0010, 8'hFF, "R10 chip cleared");
        rd(16'h0021, 8'hFF, "R10 chip cleared 2");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule